// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between the load/store port of a pipelined processor and a main memory that moves data in bursts. It holds 256 lines of four 32-bit words (1K words in total), each line tagged with the upper address bits and carrying a valid flag and a dirty flag. A load or store that finds its line present completes in the cycle it is presented. Anything else holds the processor off while the line is brought in from memory.

Stores that hit only change the cache and mark the line dirty. Memory receives the data only when a dirty line is displaced. A store that misses never installs a partial line. The full block is read first, and the held store then lands on the refilled line. When the line being replaced is dirty, its four words go back to memory before the refill command is issued.

The processor holds its request stable until `cpu_ready` is seen high at a clock edge. The memory side takes one command at a time. A command is a block address plus a direction flag, acknowledged by the memory, and it is followed by four data beats in ascending word order.

Top module: `dcache_wb`

## Requirements
- R1: A byte address splits into tag [31:12], line index [11:4], word-in-line [3:2] and byte [1:0]. Every memory command carries the block address {tag, index, 4'b0000}.
- R2: After reset every line is invalid, `cpu_ready` is high while no request is presented, no memory command is pending, and the first reference to any block misses.
- R3: A read whose line is valid with a matching tag raises `cpu_ready` in the cycle it is presented, returns the stored word on `cpu_rdata`, and issues no memory command.
- R4: On a read miss `cpu_ready` is low from the cycle the miss is seen. Exactly one read command (`mem_we`=0) is issued and four words are accepted in ascending order. The request then completes with the requested word.
- R5: A store that hits writes only the cache and sets the line's dirty flag. No memory command is issued and memory keeps its old contents.
- R6: A store that misses first reads the whole block from memory and then merges the store. Afterwards the other three words of the line read back the memory's values, and memory is not written by the store itself.
- R7: When a miss displaces a dirty line, a write-back command (`mem_we`=1) to the old block's address is issued before the read command. It carries the line's four words in ascending order, including every store merged into it.
- R8: When a miss displaces a clean or invalid line, no write-back command is issued.
- R9: A line refilled for a read is clean. Displacing it later without an intervening store causes no write-back.
- R10: A memory command is held stable until `mem_ack`. A write-back word is held stable until `mem_wready`. Acknowledge delays and gaps in either data stream do not change any result.
- R11: The byte offset bits [1:0] have no effect on hit detection or on the word returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes at this edge (low = stall) |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory command pending |
| mem_we | output | 1 | 1 = write-back of a line, 0 = block read |
| mem_addr | output | 32 | Block-aligned byte address of the command |
| mem_ack | input | 1 | Memory accepts the pending command |
| mem_wdata | output | 32 | Write-back word |
| mem_wvalid | output | 1 | Write-back word is present |
| mem_wready | input | 1 | Memory takes the write-back word at this edge |
| mem_rdata | input | 32 | Refill word |
| mem_rvalid | input | 1 | Refill word is present at this edge |

## Verification
The embedded properties watch the memory handshake on every cycle. They check that a command and a pending write-back word are held steady, that the last write-back beat is followed straight away by a read command, and that a detected miss drops `cpu_ready`. They also check that each refill leaves its line valid, clean and correctly tagged, and that a store hit leaves its line dirty. Data correctness across a whole sequence can only come from the bench scenarios. These cover which words a write-back carries, whether a merged store and its memory-supplied neighbours survive eviction, and whether ping-pong conflicts and read-filled lines cause the right amount of memory traffic. The bench compares against an arithmetic memory image and a shadow of the expected tags, under varied acknowledge delays and data gaps.

// File: rtl/dcwb_pkg.sv
package dcwb_pkg;

   // Controller sequencing: lookup, optional line flush, block refill.
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WB_CMD  = 3'd1,
      ST_WB_DATA = 3'd2,
      ST_RD_CMD  = 3'd3,
      ST_RD_DATA = 3'd4
   } dcwb_state_e;

endpackage

// File: rtl/dcwb_tags.sv
module dcwb_tags #(
   parameter int LINES = 256,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [TAG_W-1:0] lk_tag,
   output logic             lk_valid,
   output logic             lk_dirty,
   input  logic             fill_we,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             mark_dirty,
   input  logic [IDX_W-1:0] dirty_idx
);

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   // Flags need a defined reset; tags are qualified by valid.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_we) begin
         valid_q[fill_idx] <= 1'b1;
         dirty_q[fill_idx] <= 1'b0;
      end else if (mark_dirty) begin
         dirty_q[dirty_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) tag_q[fill_idx] <= fill_tag;
   end

   assign lk_tag   = tag_q[lk_idx];
   assign lk_valid = valid_q[lk_idx];
   assign lk_dirty = dirty_q[lk_idx];

   // R9: a completed refill leaves the line valid, clean and retagged
   p_fill_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we |=> valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]
                  && (tag_q[$past(fill_idx)] == $past(fill_tag)));

   // R5: a store hit leaves its line dirty and still valid
   p_hit_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_dirty && !fill_we) |=> dirty_q[$past(dirty_idx)] && valid_q[$past(dirty_idx)]);

endmodule

// File: rtl/dcwb_data.sv
module dcwb_data #(
   parameter int LINES  = 256,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WSEL_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data,
   input  logic [IDX_W-1:0]  wb_idx,
   input  logic [WSEL_W-1:0] wb_word,
   output logic [DATA_W-1:0] wb_data
);

   logic [WORDS-1:0][DATA_W-1:0] cpu_row;
   logic [WORDS-1:0][DATA_W-1:0] wb_row;

   // One bank per word position so a beat writes one bank only.
   for (genvar w = 0; w < WORDS; w++) begin : g_bank
      logic [DATA_W-1:0] bank_q [LINES];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_word == WSEL_W'(w))) bank_q[wr_idx] <= wr_data;
      end

      assign cpu_row[w] = bank_q[rd_idx];
      assign wb_row[w]  = bank_q[wb_idx];
   end

   assign rd_data = cpu_row[rd_word];
   assign wb_data = wb_row[wb_word];

endmodule

// File: rtl/dcwb_fsm.sv
module dcwb_fsm
   import dcwb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 20,
   parameter int IDX_W  = 8,
   parameter int WSEL_W = 2,
   parameter int BYTE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic              lk_hit,
   input  logic              lk_valid,
   input  logic              lk_dirty,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic              mem_ack,
   input  logic              mem_wready,
   input  logic              mem_rvalid,
   output logic              cpu_ready,
   output logic              wr_hit,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_wvalid,
   output logic              beat_we,
   output logic              fill_done,
   output logic [IDX_W-1:0]  miss_idx,
   output logic [TAG_W-1:0]  miss_tag,
   output logic [WSEL_W-1:0] beat
);

   localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'((1 << WSEL_W) - 1);
   localparam int LOW_W = WSEL_W + BYTE_W;

   dcwb_state_e      state_q;
   logic [TAG_W-1:0] vict_q;
   logic             last_beat;

   assign last_beat = (beat == LAST_BEAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         beat     <= '0;
         miss_idx <= '0;
         miss_tag <= '0;
         vict_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_req && !lk_hit) begin
                  miss_idx <= req_idx;
                  miss_tag <= req_tag;
                  vict_q   <= lk_tag;
                  state_q  <= (lk_valid && lk_dirty) ? ST_WB_CMD : ST_RD_CMD;
               end
            end
            ST_WB_CMD: begin
               if (mem_ack) begin
                  beat    <= '0;
                  state_q <= ST_WB_DATA;
               end
            end
            ST_WB_DATA: begin
               if (mem_wready) begin
                  beat <= beat + 1'b1;
                  if (last_beat) state_q <= ST_RD_CMD;
               end
            end
            ST_RD_CMD: begin
               if (mem_ack) begin
                  beat    <= '0;
                  state_q <= ST_RD_DATA;
               end
            end
            ST_RD_DATA: begin
               if (mem_rvalid) begin
                  beat <= beat + 1'b1;
                  if (last_beat) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // After a refill the held request is looked up again and completes as a hit.
   assign cpu_ready  = (state_q == ST_IDLE) && (!cpu_req || lk_hit);
   assign wr_hit     = (state_q == ST_IDLE) && cpu_req && cpu_we && lk_hit;
   assign mem_req    = (state_q == ST_WB_CMD) || (state_q == ST_RD_CMD);
   assign mem_we     = (state_q == ST_WB_CMD);
   assign mem_addr   = {(state_q == ST_WB_CMD) ? vict_q : miss_tag, miss_idx, {LOW_W{1'b0}}};
   assign mem_wvalid = (state_q == ST_WB_DATA);
   assign beat_we    = (state_q == ST_RD_DATA) && mem_rvalid;
   assign fill_done  = beat_we && last_beat;

   // R10: an unacknowledged command does not move
   p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R7: the flush of a dirty victim is followed directly by the refill command
   p_flush_then_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wvalid) |-> (mem_req && !mem_we));

   // R4: a miss seen at lookup stalls the processor in the next cycle
   p_miss_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && cpu_req && !lk_hit) |=> !cpu_ready);

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINES      = 256,
   parameter int LINE_WORDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wvalid,
   input  logic              mem_wready,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid
);

   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WSEL_W = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W;

   // Elaboration-time guards on the configuration.
   if ((1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two");
   end
   if (((1 << WSEL_W) != LINE_WORDS) || (LINE_WORDS < 2)) begin : g_bad_words
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if ((DATA_W % 8) != 0 || DATA_W < 16) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes, at least 16");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the configured geometry");
   end

   // Address split (R1, R11: the byte bits take no part).
   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_idx;
   logic [WSEL_W-1:0] req_word;
   logic              unused_byte_bits;

   assign req_tag          = cpu_addr[ADDR_W-1 -: TAG_W];
   assign req_idx          = cpu_addr[BYTE_W+WSEL_W +: IDX_W];
   assign req_word         = cpu_addr[BYTE_W +: WSEL_W];
   assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

   logic [TAG_W-1:0]  lk_tag;
   logic              lk_valid, lk_dirty, lk_hit;
   logic              wr_hit, beat_we, fill_done;
   logic [IDX_W-1:0]  miss_idx;
   logic [TAG_W-1:0]  miss_tag;
   logic [WSEL_W-1:0] beat;

   assign lk_hit = lk_valid && (lk_tag == req_tag);

   dcwb_tags #(
      .LINES (LINES),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_idx     (req_idx),
      .lk_tag     (lk_tag),
      .lk_valid   (lk_valid),
      .lk_dirty   (lk_dirty),
      .fill_we    (fill_done),
      .fill_idx   (miss_idx),
      .fill_tag   (miss_tag),
      .mark_dirty (wr_hit),
      .dirty_idx  (req_idx)
   );

   // Refill beats and store hits never coincide, so one write port serves both.
   logic              dw_en;
   logic [IDX_W-1:0]  dw_idx;
   logic [WSEL_W-1:0] dw_word;
   logic [DATA_W-1:0] dw_data;

   assign dw_en   = beat_we || wr_hit;
   assign dw_idx  = beat_we ? miss_idx  : req_idx;
   assign dw_word = beat_we ? beat      : req_word;
   assign dw_data = beat_we ? mem_rdata : cpu_wdata;

   dcwb_data #(
      .LINES  (LINES),
      .WORDS  (LINE_WORDS),
      .DATA_W (DATA_W)
   ) u_data (
      .clk     (clk),
      .wr_en   (dw_en),
      .wr_idx  (dw_idx),
      .wr_word (dw_word),
      .wr_data (dw_data),
      .rd_idx  (req_idx),
      .rd_word (req_word),
      .rd_data (cpu_rdata),
      .wb_idx  (miss_idx),
      .wb_word (beat),
      .wb_data (mem_wdata)
   );

   dcwb_fsm #(
      .ADDR_W (ADDR_W),
      .TAG_W  (TAG_W),
      .IDX_W  (IDX_W),
      .WSEL_W (WSEL_W),
      .BYTE_W (BYTE_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .req_idx    (req_idx),
      .req_tag    (req_tag),
      .lk_hit     (lk_hit),
      .lk_valid   (lk_valid),
      .lk_dirty   (lk_dirty),
      .lk_tag     (lk_tag),
      .mem_ack    (mem_ack),
      .mem_wready (mem_wready),
      .mem_rvalid (mem_rvalid),
      .cpu_ready  (cpu_ready),
      .wr_hit     (wr_hit),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wvalid (mem_wvalid),
      .beat_we    (beat_we),
      .fill_done  (fill_done),
      .miss_idx   (miss_idx),
      .miss_tag   (miss_tag),
      .beat       (beat)
   );

   // R10: a write-back word waiting for the memory stays put
   p_wdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wvalid && !mem_wready) |=> mem_wvalid && $stable(mem_wdata));

endmodule

// File: tb/dcache_wb_tb.sv
module dcache_wb_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we, mem_wvalid;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0, mem_wready = 1'b0, mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   // 8-unit period: 125 MHz with 1 ns units
   always #4 clk = ~clk;

   dcache_wb u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_wdata(mem_wdata), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // Memory image: arithmetic initial contents, overridden by write-backs.
   logic [31:0] back_mem [int unsigned];
   logic [31:0] ref_mem  [int unsigned];

   function automatic logic [31:0] init_word(input int unsigned k);
      return (k * 32'd2654435761) + 32'h0BAD_F00D;
   endfunction
   function automatic logic [31:0] back_rd(input int unsigned k);
      return back_mem.exists(k) ? back_mem[k] : init_word(k);
   endfunction
   function automatic logic [31:0] ref_rd(input int unsigned k);
      return ref_mem.exists(k) ? ref_mem[k] : init_word(k);
   endfunction
   function automatic logic [31:0] mk(input int tag, input int idx, input int wd, input int by);
      return {tag[19:0], idx[7:0], wd[1:0], by[1:0]};
   endfunction

   // Responder bookkeeping
   int          n_wb = 0, n_rd = 0, evt = 0, wb_seq = 0, rd_seq = 0;
   logic [31:0] last_wb = '0, last_rd = '0;
   int          ack_dly = 0;
   bit          slow = 1'b0;

   initial begin : responder
      int phase, beat, waitc, tick;
      int unsigned base;
      phase = 0; beat = 0; waitc = 0; tick = 0; base = 0;
      forever begin
         @(negedge clk);
         tick++;
         mem_ack = 1'b0; mem_rvalid = 1'b0; mem_wready = 1'b0;
         if (!rst_n) begin
            phase = 0;
         end else begin
            case (phase)
               0: if (mem_req) begin
                  if (waitc >= ack_dly) begin
                     mem_ack = 1'b1; waitc = 0; beat = 0; base = mem_addr >> 2; evt++;
                     if (mem_we) begin n_wb++; last_wb = mem_addr; wb_seq = evt; phase = 2; end
                     else begin n_rd++; last_rd = mem_addr; rd_seq = evt; phase = 1; end
                  end else waitc++;
               end
               1: if (!(slow && (tick % 3 == 0))) begin
                  mem_rvalid = 1'b1;
                  mem_rdata  = back_rd(base + beat);
                  beat++;
                  if (beat == 4) phase = 0;
               end
               2: if (!(slow && (tick % 3 == 1))) begin
                  mem_wready = 1'b1;
                  if (mem_wvalid) begin
                     back_mem[base + beat] = mem_wdata;
                     beat++;
                     if (beat == 4) phase = 0;
                  end
               end
               default: phase = 0;
            endcase
         end
      end
   end

   // Expected line state, from the requirements
   logic [19:0] exp_tag [256];
   bit          exp_val [256];
   bit          exp_dirty [256];

   task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd, input string ctx);
      int          idx, cyc, wb0, rd0;
      int unsigned wkey, vbase;
      logic [19:0] tag, vict;
      bit          hit, wbx, first;
      logic [31:0] rd, back_before;
      idx   = int'(addr[11:4]);
      tag   = addr[31:12];
      wkey  = addr >> 2;
      hit   = exp_val[idx] && (exp_tag[idx] == tag);
      first = !exp_val[idx];
      wbx   = !hit && exp_val[idx] && exp_dirty[idx];
      vict  = exp_tag[idx];
      back_before = back_rd(wkey);
      @(negedge clk);
      wb0 = n_wb; rd0 = n_rd;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      cyc = 0;
      #1;
      while (!cpu_ready && cyc < 2000) begin
         @(negedge clk); #1; cyc++;
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0;
      chk(cyc < 2000, {ctx, " access completes"}, cyc, 0);
      chk((cyc == 0) == hit,
          hit ? {ctx, " R3 hit ready at once"} : (first ? {ctx, " R2 first reference misses"} : {ctx, " R4 miss stalls"}),
          cyc, hit ? 0 : 1);
      if (!we) chk(rd == ref_rd(wkey), {ctx, " R3 R4 R11 load data"}, rd, ref_rd(wkey));
      else     chk(back_rd(wkey) == back_before, {ctx, " R5 R6 store not written through"}, back_rd(wkey), back_before);
      chk((n_rd - rd0) == (hit ? 0 : 1), {ctx, " R4 R5 R6 read command count"}, n_rd - rd0, hit ? 0 : 1);
      chk((n_wb - wb0) == (wbx ? 1 : 0), {ctx, " R7 R8 R9 write-back count"}, n_wb - wb0, wbx ? 1 : 0);
      if (!hit) chk(last_rd == {tag, addr[11:4], 4'b0}, {ctx, " R1 refill address"}, last_rd, {tag, addr[11:4], 4'b0});
      if (wbx) begin
         chk(last_wb == {vict, addr[11:4], 4'b0}, {ctx, " R1 R7 write-back address"}, last_wb, {vict, addr[11:4], 4'b0});
         chk(wb_seq < rd_seq, {ctx, " R7 write-back precedes refill"}, wb_seq, rd_seq);
         vbase = {vict, addr[11:4], 4'b0} >> 2;
         for (int w = 0; w < 4; w++)
            chk(back_rd(vbase + w) == ref_rd(vbase + w), {ctx, " R7 write-back word"},
                back_rd(vbase + w), ref_rd(vbase + w));
      end
      exp_val[idx] = 1'b1;
      exp_tag[idx] = tag;
      if (!hit) exp_dirty[idx] = 1'b0;
      if (we) begin
         exp_dirty[idx] = 1'b1;
         ref_mem[wkey] = wd;
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      finish_run();
   end

   initial begin : main
      logic [31:0] seed;
      for (int i = 0; i < 256; i++) begin exp_val[i] = 1'b0; exp_dirty[i] = 1'b0; exp_tag[i] = '0; end
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(cpu_ready === 1'b1, "R2 idle ready after reset", cpu_ready, 1);
      chk(mem_req === 1'b0, "R2 no command after reset", mem_req, 0);

      // Cold sweep of every line, then every other word with nonzero byte offsets
      for (int i = 0; i < 256; i++) access(1'b0, mk(1, i, 0, 0), '0, "R2 cold sweep");
      for (int i = 0; i < 256; i++)
         for (int w = 1; w < 4; w++) access(1'b0, mk(1, i, w, (i + w) % 4), '0, "R3 R11 warm sweep");

      // Store hits stay in the cache
      for (int i = 0; i < 16; i++) access(1'b1, mk(1, i, 2, 1), 32'hA000_0000 + i, "R5 store hit");
      for (int i = 0; i < 16; i++) access(1'b0, mk(1, i, 2, 3), '0, "R5 store readback");

      // Dirty eviction, then clean eviction of the read-filled replacement
      for (int i = 0; i < 16; i++) access(1'b0, mk(2, i, 0, 0), '0, "R7 dirty eviction");
      for (int i = 0; i < 16; i++) access(1'b0, mk(1, i, 2, 0), '0, "R9 clean eviction");

      // Store miss: whole block first, neighbours from memory, then eviction
      access(1'b1, mk(5, 100, 1, 0), 32'h5EED_1234, "R6 store miss");
      for (int w = 0; w < 4; w++) access(1'b0, mk(5, 100, w, 2), '0, "R6 neighbour word");
      access(1'b0, mk(6, 100, 3, 0), '0, "R6 R7 merged line eviction");

      // Ping-pong conflict on one line
      for (int k = 0; k < 8; k++) access(1'b0, mk(3 + (k % 2), 200, k % 4, 0), '0, "R8 ping-pong");

      // Mixed traffic on a few lines with slow handshakes
      slow = 1'b1;
      ack_dly = 2;
      seed = 32'h1357_9BDF;
      for (int n = 0; n < 1500; n++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         access(seed[20], mk(int'(seed[25:24]), int'(seed[18:16]), int'(seed[13:12]), int'(seed[9:8])),
                seed ^ 32'h00FF_F0F0, "R10 slow mixed");
         if (n == 700) ack_dly = 0;
      end

      finish_run();
   end

endmodule